// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block makes the serial clock for an SPI master and tells the shift register next to it when to drive a new bit and when to capture an incoming one. The division ratio comes from a 5-bit prescale code that has two ranges. Codes without the top bit divide by the code itself. Codes with the top bit set divide by twice their low four bits, so the slow end runs in even steps up to a ratio of 30. Codes that would give a ratio of zero are read as a ratio of 1.

The block runs from a core clock at twice the reference rate. One SCLK period therefore lasts 2·N core cycles, where N is the decoded ratio, and SCLK equals the reference clock divided by N.

Clock polarity and clock phase select one of the four usual SPI modes. A late-capture control moves the sample strobe onto the launch edge, which suits the fastest ratios of 2 or less. Raising `run` starts the clock, and the ratio and mode are fixed at that moment. Lowering `run` lets the current period finish, and SCLK then rests at its polarity level.

Top module: `spi_sclk_gen`

## Requirements
- R1: A code from 1 to 15 (bit 4 clear) gives ratio N equal to the code. While running, SCLK toggles once every N core cycles.
- R2: A code with bit 4 set gives N equal to twice the value in bits 3:0. Code 31 gives the largest ratio, 30.
- R3: Code 0 and code 16 both give N = 1.
- R4: While idle, `launch_en` and `sample_en` stay low. From the second cycle of idle onward, `sclk` equals the `cpol` input sampled on the previous clock. After reset, `sclk` is 0.
- R5: If `run` is sampled high on edge E while the block is idle, the first SCLK edge appears on edge E+N. Each later edge follows N cycles after the one before it.
- R6: The leading edge moves SCLK away from the polarity level and the trailing edge returns it. With `cpha`=0, `sample_en` pulses on leading edges and `launch_en` on trailing edges. With `cpha`=1 it is the other way round.
- R7: With `late_capture`=1, `sample_en` pulses on the same edges as `launch_en` instead of on its normal edge.
- R8: Prescale code, `cpol`, `cpha` and `late_capture` are latched when a run starts. Changes made during a run have no effect until the next start.
- R9: When `run` is low at a leading-edge boundary, the block goes idle and makes no edge there. If `run` falls while SCLK is away from its polarity level, the trailing edge and its strobe still occur.
- R10: Each strobe is a one-cycle pulse in the same cycle that `sclk` shows the new level. Every SCLK period holds exactly one launch pulse and one sample pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_code | input | 5 | Prescale code; bit 4 selects the even range |
| cpol | input | 1 | Idle level of SCLK |
| cpha | input | 1 | 0: sample on leading edge; 1: launch on leading edge |
| late_capture | input | 1 | Moves sampling onto the launch edge |
| run | input | 1 | High to run SCLK; low to stop at the next period boundary |
| sclk | output | 1 | Serial clock |
| launch_en | output | 1 | One-cycle strobe: shift register drives its next bit |
| sample_en | output | 1 | One-cycle strobe: shift register captures the input bit |

## Verification
`sclk`, `launch_en` and `sample_en` all come from registers updated on the same edge. After `run` is sampled high, the k-th SCLK edge with its strobes becomes visible exactly k·N cycles later. After `run` is sampled low at a leading-edge boundary, the outputs hold still from that edge on. The bench changes inputs and reads outputs only on falling clock edges. It counts falling edges from the start edge and compares all three outputs on every cycle against the value that count predicts, so a single cycle of slip in any output is a miscompare. The prescale code is changed during a run, and `run` is dropped both in the idle half and in the active half of a period, to check the hold and stop rules.

// File: rtl/spi_sclk_pkg.sv
`timescale 1ns/1ps
package spi_sclk_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEAD  = 2'd1,
    EDGE_TRAIL = 2'd2
  } sclk_edge_e;
endpackage

// File: rtl/spi_presc_decode.sv
`timescale 1ns/1ps
module spi_presc_decode #(
  parameter int CODE_W = 5
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] ratio
);
  localparam int LOW_W = CODE_W - 1;

  logic [LOW_W-1:0] low_bits;
  logic [CODE_W-1:0] raw;

  assign low_bits = code[LOW_W-1:0];

  always_comb begin
    if (code[CODE_W-1]) raw = {low_bits, 1'b0};
    else                raw = code;
    ratio = (raw == '0) ? CODE_W'(1) : raw;
  end
endmodule

// File: rtl/spi_half_timer.sv
`timescale 1ns/1ps
module spi_half_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] ratio,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = active && (cnt_q == ratio - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!active || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_edge_steer.sv
`timescale 1ns/1ps
module spi_edge_steer
  import spi_sclk_pkg::*;
(
  input  sclk_edge_e edge_kind,
  input  logic       cpha,
  input  logic       late,
  output logic       launch,
  output logic       sample
);
  logic is_lead, is_trail, normal_sample;

  always_comb begin
    is_lead       = (edge_kind == EDGE_LEAD);
    is_trail      = (edge_kind == EDGE_TRAIL);
    launch        = cpha ? is_lead : is_trail;
    normal_sample = cpha ? is_trail : is_lead;
    sample        = late ? launch : normal_sample;
  end
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] presc_code,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              late_capture,
  input  logic              run,
  output logic              sclk,
  output logic              launch_en,
  output logic              sample_en
);
  logic              running_q, sclk_q, pol_q, cpha_q, late_q;
  logic              launch_q, sample_q;
  logic [CODE_W-1:0] ratio_q, ratio_dec;
  logic              tick, launch_d, sample_d;
  sclk_edge_e        edge_kind;

  spi_presc_decode #(.CODE_W(CODE_W)) u_dec (
    .code  (presc_code),
    .ratio (ratio_dec)
  );

  spi_half_timer #(.CNT_W(CODE_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (running_q),
    .ratio  (ratio_q),
    .tick   (tick)
  );

  always_comb begin
    edge_kind = EDGE_NONE;
    if (running_q && tick) begin
      if (sclk_q != pol_q)  edge_kind = EDGE_TRAIL;
      else if (run)         edge_kind = EDGE_LEAD;
    end
  end

  spi_edge_steer u_steer (
    .edge_kind (edge_kind),
    .cpha      (cpha_q),
    .late      (late_q),
    .launch    (launch_d),
    .sample    (sample_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      sclk_q    <= 1'b0;
      pol_q     <= 1'b0;
      cpha_q    <= 1'b0;
      late_q    <= 1'b0;
      ratio_q   <= CODE_W'(1);
      launch_q  <= 1'b0;
      sample_q  <= 1'b0;
    end else begin
      launch_q <= launch_d;
      sample_q <= sample_d;
      if (!running_q) begin
        sclk_q <= cpol;
        pol_q  <= cpol;
        if (run) begin
          running_q <= 1'b1;
          ratio_q   <= ratio_dec;
          cpha_q    <= cpha;
          late_q    <= late_capture;
        end
      end else if (tick) begin
        if (edge_kind == EDGE_NONE) running_q <= 1'b0;
        else                        sclk_q    <= ~sclk_q;
      end
    end
  end

  assign sclk      = sclk_q;
  assign launch_en = launch_q;
  assign sample_en = sample_q;
endmodule

// File: rtl/spi_sclk_gen_chk.sv
`timescale 1ns/1ps
module spi_sclk_gen_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpol,
  input logic              sclk,
  input logic              launch_en,
  input logic              sample_en,
  input logic              running_q,
  input logic              late_q,
  input logic [CODE_W-1:0] ratio_q
);
  localparam int MAX_RATIO = 2 * ((1 << (CODE_W - 1)) - 1);

  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (ratio_q >= CODE_W'(1)) && (32'(ratio_q) <= MAX_RATIO)); // R2

  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && running_q && $past(running_q) |-> $stable(ratio_q)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> !launch_en && !sample_en); // R4

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !running_q && !$past(running_q) |-> sclk == $past(cpol)); // R4

  AST_STROBE_AT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (launch_en || sample_en) |-> sclk != $past(sclk)); // R10

  AST_SPLIT_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    running_q && !late_q |-> !(launch_en && sample_en)); // R6

  AST_LATE_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
    running_q && late_q |-> launch_en == sample_en); // R7
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpol      (cpol),
  .sclk      (sclk),
  .launch_en (launch_en),
  .sample_en (sample_en),
  .running_q (running_q),
  .late_q    (late_q),
  .ratio_q   (ratio_q)
);

// File: tb/spi_sclk_gen_test.sv
`timescale 1ns/1ps
module spi_sclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] presc_code = 5'd0;
  logic       cpol = 1'b1;
  logic       cpha = 1'b0;
  logic       late_capture = 1'b0;
  logic       run = 1'b0;
  logic       sclk, launch_en, sample_en;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  spi_sclk_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .presc_code   (presc_code),
    .cpol         (cpol),
    .cpha         (cpha),
    .late_capture (late_capture),
    .run          (run),
    .sclk         (sclk),
    .launch_en    (launch_en),
    .sample_en    (sample_en)
  );

  // fields: code[12:8] cpol[7] cpha[6] late[5] ratio[4:0]
  localparam logic [12:0] VEC [10] = '{
    {5'd0,  1'b0, 1'b0, 1'b0, 5'd1},   // R3 code 0
    {5'd1,  1'b0, 1'b1, 1'b0, 5'd1},   // R1
    {5'd2,  1'b0, 1'b0, 1'b1, 5'd2},   // R7
    {5'd3,  1'b1, 1'b0, 1'b0, 5'd3},   // R1 R6
    {5'd7,  1'b1, 1'b1, 1'b0, 5'd7},   // R6
    {5'd15, 1'b0, 1'b1, 1'b1, 5'd15},  // R7
    {5'd16, 1'b0, 1'b0, 1'b0, 5'd1},   // R3 code 16
    {5'd17, 1'b1, 1'b0, 1'b0, 5'd2},   // R2
    {5'd21, 1'b0, 1'b1, 1'b0, 5'd10},  // R2
    {5'd31, 1'b1, 1'b1, 1'b1, 5'd30}   // R2 max
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs 3 full periods, stops, then watches the idle tail.
  task automatic run_vec(input logic [4:0] code, input logic pol, input logic ph,
                         input logic lt, input int n, input logic [4:0] alt,
                         input string req);
    int  miss = 0;
    logic [2:0] first_act = 3'b0, first_exp = 3'b0;
    @(negedge clk);
    presc_code = code; cpol = pol; cpha = ph; late_capture = lt; run = 1'b1;
    @(negedge clk);
    for (int k = 1; k <= 8 * n; k++) begin
      int  j;
      logic lead, lau, nsm, smp, sc;
      @(negedge clk);
      j    = (k / n > 6) ? 6 : k / n;
      sc   = pol ^ j[0];
      lead = j[0];
      lau = 1'b0; smp = 1'b0;
      if ((k % n == 0) && (k <= 6 * n)) begin
        lau = ph ? lead : !lead;
        nsm = ph ? !lead : lead;
        smp = lt ? lau : nsm;
      end
      if ({sclk, launch_en, sample_en} !== {sc, lau, smp}) begin
        if (miss == 0) begin
          first_act = {sclk, launch_en, sample_en};
          first_exp = {sc, lau, smp};
        end
        miss++;
      end
      if (k == 1) presc_code = alt;
      if (k == 6 * n) run = 1'b0;
    end
    check(miss == 0, req, int'(first_act), int'(first_exp));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R4 reset state
    repeat (3) @(negedge clk);
    check({sclk, launch_en, sample_en} === 3'b000, "R4 reset", {sclk, launch_en, sample_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({sclk, launch_en, sample_en} === 3'b100, "R4 idle level cpol=1",
          {sclk, launch_en, sample_en}, 3'b100);

    // Table walk: R1 R2 R3 R5 R6 R7 R9 R10
    for (int v = 0; v < 10; v++) begin
      logic [12:0] e;
      e = VEC[v];
      run_vec(e[12:8], e[7], e[6], e[5], int'(e[4:0]), e[12:8],
              $sformatf("R1 R2 R3 R5 R6 R7 R10 vec%0d", v));
      repeat (2) @(negedge clk);
    end

    // R8: code change during a run is ignored, used at the next start
    run_vec(5'd2, 1'b0, 1'b1, 1'b0, 2, 5'd9, "R8 held ratio");
    repeat (2) @(negedge clk);
    run_vec(5'd9, 1'b1, 1'b0, 1'b0, 9, 5'd9, "R8 new ratio at start");
    repeat (2) @(negedge clk);

    // R9: run drops while SCLK is at its active level
    begin
      int miss = 0;
      @(negedge clk);
      presc_code = 5'd3; cpol = 1'b0; cpha = 1'b0; late_capture = 1'b0; run = 1'b1;
      @(negedge clk);
      for (int k = 1; k <= 12; k++) begin
        logic sc;
        @(negedge clk);
        sc = (k >= 3 && k < 6);
        if ({sclk, launch_en, sample_en} !== {sc, (k == 6), (k == 3)}) miss++;
        if (k == 3) run = 1'b0;
      end
      check(miss == 0, "R9 trailing edge completes", miss, 0);
    end

    // R4: idle level follows cpol changes
    @(negedge clk); cpol = 1'b1;
    @(negedge clk); @(negedge clk);
    check({sclk, launch_en, sample_en} === 3'b100, "R4 idle follows cpol",
          {sclk, launch_en, sample_en}, 3'b100);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule